// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page mappings for a processor's memory pipeline. Each slot holds a virtual page tag, an 8-bit address-space number, a global flag, a physical page number and a permission record. The permission record has a read-enable mask and a write-enable mask, with one bit per privilege mode, plus a trap-on-read flag and a trap-on-write flag. A lookup presents a page number and the current address-space number. It returns, in the same cycle, whether some slot hits, which slot it is, and that slot's fields.

New mappings are written through the insert port into the slot chosen by a rotating victim pointer. Three invalidation commands keep the buffer coherent with software:
- A global wipe clears every slot.
- A per-process purge drops only the non-global slots.
- A single-page purge drops the slots that would hit for a given page and address-space number.

All updates are registered and become visible after the next rising clock edge.

Top module: `xlat_cam`

## Requirements
- R1: While reset is low, every slot becomes invalid and the victim pointer returns to slot 0. After reset no lookup hits, and the first insert lands in slot 0.
- R2: A slot hits only if all three hold: it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address-space number equals all 8 bits of `lk_asn`.
- R3: On a hit, `lk_ppn`, `lk_rd_ok`, `lk_wr_ok`, `lk_trap_rd` and `lk_trap_wr` carry the hitting slot's stored values. On a miss these outputs and `lk_idx` are all zero.
- R4: When several slots hit, the lowest-numbered one is reported, and `lk_idx` gives its slot number.
- R5: An accepted insert writes the slot under the victim pointer, overwriting any valid mapping there. It marks that slot valid and advances the pointer by one.
- R6: The victim pointer returns to slot 0 after the last slot (DEPTH-1).
- R7: `fl_all` invalidates every slot and resets the victim pointer to slot 0.
- R8: `fl_proc` invalidates every slot whose global flag is clear, and leaves global slots valid.
- R9: `fl_addr` invalidates every valid slot whose tag equals `fl_vpn` and whose global flag is set or whose address-space number equals `fl_asn`. Other slots are left untouched.
- R10: If an insert arrives in the same cycle as any flush command, the insert is dropped and the victim pointer does not move.
- R11: A lookup is combinational from the stored slots. A write or flush first shows at the lookup outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Some slot matches the lookup |
| lk_idx | output | $clog2(DEPTH) | Number of the reported slot |
| lk_ppn | output | PPN_W | Physical page number of the reported slot |
| lk_rd_ok | output | 4 | Read-enable mask, one bit per privilege mode |
| lk_wr_ok | output | 4 | Write-enable mask, one bit per privilege mode |
| lk_trap_rd | output | 1 | Trap-on-read flag |
| lk_trap_wr | output | 1 | Trap-on-write flag |
| ins_en | input | 1 | Write a new mapping this cycle |
| ins_vpn | input | VPN_W | Tag for the new mapping |
| ins_asn | input | ASN_W | Address-space number for the new mapping |
| ins_glb | input | 1 | Global flag for the new mapping |
| ins_ppn | input | PPN_W | Physical page number for the new mapping |
| ins_rd_ok | input | 4 | Read-enable mask for the new mapping |
| ins_wr_ok | input | 4 | Write-enable mask for the new mapping |
| ins_trap_rd | input | 1 | Trap-on-read flag for the new mapping |
| ins_trap_wr | input | 1 | Trap-on-write flag for the new mapping |
| fl_all | input | 1 | Invalidate all slots and reset the victim pointer |
| fl_proc | input | 1 | Invalidate all non-global slots |
| fl_addr | input | 1 | Invalidate the slots matching `fl_vpn`/`fl_asn` |
| fl_vpn | input | VPN_W | Page number for the single-page purge |
| fl_asn | input | ASN_W | Address-space number for the single-page purge |

## Verification
Internal state can go wrong in three ways, and each shows at the ports differently:
- A wrong valid bit or stored tag shows on the very next lookup of that page, as a stale hit or a missing hit.
- A victim pointer that skips or sticks shows only when a later insert reports an unexpected `lk_idx`. That can take up to DEPTH inserts, for example when a mapping that should have been overwritten survives a full rotation.
- A wrong global flag stays hidden until a per-process or single-page purge, when a slot is dropped or kept against R8 or R9.

For these reasons the stimulus always follows each update with lookups at the exact slot and address-space numbers concerned.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // privilege modes covered by each permission mask
   localparam int MODE_CNT = 4;

   typedef struct packed {
      logic [MODE_CNT-1:0] rd_ok;
      logic [MODE_CNT-1:0] wr_ok;
      logic                trap_rd;
      logic                trap_wr;
   } xlat_perm_t;

endpackage

// File: rtl/xlat_slot.sv
module xlat_slot
   import xlat_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int ASN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VPN_W-1:0] ld_vpn,
   input  logic [ASN_W-1:0] ld_asn,
   input  logic             ld_glb,
   input  logic [PPN_W-1:0] ld_ppn,
   input  xlat_perm_t       ld_perm,
   input  logic             kill_all,
   input  logic             kill_proc,
   input  logic             kill_addr,
   input  logic [VPN_W-1:0] kl_vpn,
   input  logic [ASN_W-1:0] kl_asn,
   input  logic [VPN_W-1:0] q_vpn,
   input  logic [ASN_W-1:0] q_asn,
   output logic             q_match,
   output logic [PPN_W-1:0] q_ppn,
   output xlat_perm_t       q_perm
);

   logic             vld;
   logic [VPN_W-1:0] tag;
   logic [ASN_W-1:0] asn;
   logic             glb;
   logic [PPN_W-1:0] ppn;
   xlat_perm_t       perm;

   logic addr_sel, proc_sel, drop;

   // single-page purge selects with the same rule as a lookup
   assign addr_sel = vld && (tag == kl_vpn) && (glb || (asn == kl_asn));
   assign proc_sel = vld && !glb;
   assign drop     = kill_all || (kill_proc && proc_sel) || (kill_addr && addr_sel);

   always_ff @(posedge clk) begin
      if (!rst_n)     vld <= 1'b0;
      else if (drop)  vld <= 1'b0;
      else if (load)  vld <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (load) begin
         tag  <= ld_vpn;
         asn  <= ld_asn;
         glb  <= ld_glb;
         ppn  <= ld_ppn;
         perm <= ld_perm;
      end
   end

   assign q_match = vld && (tag == q_vpn) && (glb || (asn == q_asn));
   assign q_ppn   = ppn;
   assign q_perm  = perm;

   // R7
   wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_all |=> !vld);

   // R8
   global_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && glb && kill_proc && !kill_all && !kill_addr) |=> vld);

   // R5
   load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !kill_all && !kill_proc && !kill_addr) |=> (vld && tag == $past(ld_vpn)));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] nxt;

   generate
      if (DEPTH == (1 << IDX_W)) begin : g_pow2
         // natural roll-over of the counter gives the wrap
         assign nxt = ptr + IDX_W'(1);
      end else begin : g_cmp
         assign nxt = (ptr == LAST) ? '0 : ptr + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear) ptr <= '0;
      else if (step)       ptr <= nxt;
   end

   // R6
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && ptr == LAST) |=> (ptr == '0));

   // R7
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ptr == '0));

   // R10
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(ptr));

   // R6
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   // scan from the top so the lowest set bit is written last
   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
   import xlat_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int ASN_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [VPN_W-1:0]    lk_vpn,
   input  logic [ASN_W-1:0]    lk_asn,
   output logic                lk_hit,
   output logic [IDX_W-1:0]    lk_idx,
   output logic [PPN_W-1:0]    lk_ppn,
   output logic [MODE_CNT-1:0] lk_rd_ok,
   output logic [MODE_CNT-1:0] lk_wr_ok,
   output logic                lk_trap_rd,
   output logic                lk_trap_wr,
   input  logic                ins_en,
   input  logic [VPN_W-1:0]    ins_vpn,
   input  logic [ASN_W-1:0]    ins_asn,
   input  logic                ins_glb,
   input  logic [PPN_W-1:0]    ins_ppn,
   input  logic [MODE_CNT-1:0] ins_rd_ok,
   input  logic [MODE_CNT-1:0] ins_wr_ok,
   input  logic                ins_trap_rd,
   input  logic                ins_trap_wr,
   input  logic                fl_all,
   input  logic                fl_proc,
   input  logic                fl_addr,
   input  logic [VPN_W-1:0]    fl_vpn,
   input  logic [ASN_W-1:0]    fl_asn
);

   generate
      if (DEPTH < 2)  begin : g_bad_depth $error("xlat_cam: DEPTH must be at least 2"); end
      if (VPN_W < 1)  begin : g_bad_vpn   $error("xlat_cam: VPN_W must be positive"); end
      if (PPN_W < 1)  begin : g_bad_ppn   $error("xlat_cam: PPN_W must be positive"); end
      if (ASN_W != 8) begin : g_bad_asn   $error("xlat_cam: address-space number is 8 bits"); end
   endgenerate

   logic             any_flush, ins_ok;
   logic [IDX_W-1:0] victim;
   logic [DEPTH-1:0] match_vec;
   logic [PPN_W-1:0] ppn_arr  [DEPTH];
   xlat_perm_t       perm_arr [DEPTH];
   xlat_perm_t       ins_perm;
   xlat_perm_t       sel_perm;

   // flushes win over an insert in the same cycle
   assign any_flush = fl_all || fl_proc || fl_addr;
   assign ins_ok    = ins_en && !any_flush;

   assign ins_perm.rd_ok   = ins_rd_ok;
   assign ins_perm.wr_ok   = ins_wr_ok;
   assign ins_perm.trap_rd = ins_trap_rd;
   assign ins_perm.trap_wr = ins_trap_wr;

   xlat_victim #(.DEPTH(DEPTH)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (fl_all),
      .step  (ins_ok),
      .ptr   (victim)
   );

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         xlat_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (ins_ok && (victim == IDX_W'(s))),
            .ld_vpn    (ins_vpn),
            .ld_asn    (ins_asn),
            .ld_glb    (ins_glb),
            .ld_ppn    (ins_ppn),
            .ld_perm   (ins_perm),
            .kill_all  (fl_all),
            .kill_proc (fl_proc),
            .kill_addr (fl_addr),
            .kl_vpn    (fl_vpn),
            .kl_asn    (fl_asn),
            .q_vpn     (lk_vpn),
            .q_asn     (lk_asn),
            .q_match   (match_vec[s]),
            .q_ppn     (ppn_arr[s]),
            .q_perm    (perm_arr[s])
         );
      end
   endgenerate

   xlat_pick #(.DEPTH(DEPTH)) u_pick (
      .req (match_vec),
      .any (lk_hit),
      .idx (lk_idx)
   );

   assign lk_ppn     = lk_hit ? ppn_arr[lk_idx] : '0;
   assign sel_perm   = lk_hit ? perm_arr[lk_idx] : '0;
   assign lk_rd_ok   = sel_perm.rd_ok;
   assign lk_wr_ok   = sel_perm.wr_ok;
   assign lk_trap_rd = sel_perm.trap_rd;
   assign lk_trap_wr = sel_perm.trap_wr;

   logic [DEPTH-1:0] below_mask;
   assign below_mask = (DEPTH'(1) << lk_idx) - DEPTH'(1);

   // R4
   lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (match_vec[lk_idx] && ((match_vec & below_mask) == '0)));

   // R7
   wipe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_all |=> !lk_hit);

   // R1
   reset_no_hit_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> !lk_hit);

endmodule

// File: tb/tb_xlat_cam.sv
`timescale 1ns/100ps
module tb_xlat_cam;

   localparam int DEPTH = 16;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int AW = 8;

   localparam logic [2:0] OP_LOOK = 3'd0, OP_INS = 3'd1, OP_ALL = 3'd2,
                          OP_PROC = 3'd3, OP_ADDR = 3'd4;

   typedef struct packed {
      logic [2:0]    op;
      logic [VW-1:0] vpn;
      logic [AW-1:0] asn;
      logic          glb;
      logic [PW-1:0] ppn;
      logic [VW-1:0] cvpn;
      logic [AW-1:0] casn;
      logic          ehit;
      logic [3:0]    eidx;
      logic [PW-1:0] eppn;
      logic [3:0]    req;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{OP_INS,  20'h100, 8'd5,  1'b0, 20'hA1, 20'h100, 8'd5,  1'b1, 4'd0, 20'hA1, 4'd5},
      '{OP_LOOK, 20'h0,   8'd0,  1'b0, 20'h0,  20'h100, 8'd6,  1'b0, 4'd0, 20'h0,  4'd2},
      '{OP_INS,  20'h200, 8'd5,  1'b1, 20'hB2, 20'h200, 8'd9,  1'b1, 4'd1, 20'hB2, 4'd2},
      '{OP_INS,  20'h100, 8'd5,  1'b0, 20'hC3, 20'h100, 8'd5,  1'b1, 4'd0, 20'hA1, 4'd4},
      '{OP_ADDR, 20'h100, 8'd7,  1'b0, 20'h0,  20'h100, 8'd5,  1'b1, 4'd0, 20'hA1, 4'd9},
      '{OP_ADDR, 20'h100, 8'd5,  1'b0, 20'h0,  20'h100, 8'd5,  1'b0, 4'd0, 20'h0,  4'd9},
      '{OP_LOOK, 20'h0,   8'd0,  1'b0, 20'h0,  20'h200, 8'd3,  1'b1, 4'd1, 20'hB2, 4'd9},
      '{OP_INS,  20'h300, 8'd2,  1'b0, 20'hD4, 20'h300, 8'd2,  1'b1, 4'd3, 20'hD4, 4'd5},
      '{OP_PROC, 20'h0,   8'd0,  1'b0, 20'h0,  20'h300, 8'd2,  1'b0, 4'd0, 20'h0,  4'd8},
      '{OP_LOOK, 20'h0,   8'd0,  1'b0, 20'h0,  20'h200, 8'd2,  1'b1, 4'd1, 20'hB2, 4'd8},
      '{OP_ADDR, 20'h200, 8'd77, 1'b0, 20'h0,  20'h200, 8'd77, 1'b0, 4'd0, 20'h0,  4'd9},
      '{OP_ALL,  20'h0,   8'd0,  1'b0, 20'h0,  20'h200, 8'd5,  1'b0, 4'd0, 20'h0,  4'd7},
      '{OP_INS,  20'h400, 8'd1,  1'b0, 20'hE5, 20'h400, 8'd1,  1'b1, 4'd0, 20'hE5, 4'd7}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asn = '0;
   logic          lk_hit;
   logic [3:0]    lk_idx;
   logic [PW-1:0] lk_ppn;
   logic [3:0]    lk_rd_ok, lk_wr_ok;
   logic          lk_trap_rd, lk_trap_wr;
   logic          ins_en = 1'b0;
   logic [VW-1:0] ins_vpn = '0;
   logic [AW-1:0] ins_asn = '0;
   logic          ins_glb = 1'b0;
   logic [PW-1:0] ins_ppn = '0;
   logic [3:0]    ins_rd_ok = '0, ins_wr_ok = '0;
   logic          ins_trap_rd = 1'b0, ins_trap_wr = 1'b0;
   logic          fl_all = 1'b0, fl_proc = 1'b0, fl_addr = 1'b0;
   logic [VW-1:0] fl_vpn = '0;
   logic [AW-1:0] fl_asn = '0;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   xlat_cam #(.DEPTH(DEPTH), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_ppn(lk_ppn), .lk_rd_ok(lk_rd_ok), .lk_wr_ok(lk_wr_ok),
      .lk_trap_rd(lk_trap_rd), .lk_trap_wr(lk_trap_wr),
      .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_glb(ins_glb),
      .ins_ppn(ins_ppn), .ins_rd_ok(ins_rd_ok), .ins_wr_ok(ins_wr_ok),
      .ins_trap_rd(ins_trap_rd), .ins_trap_wr(ins_trap_wr),
      .fl_all(fl_all), .fl_proc(fl_proc), .fl_addr(fl_addr),
      .fl_vpn(fl_vpn), .fl_asn(fl_asn)
   );

   task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_ctrl();
      ins_en = 1'b0; fl_all = 1'b0; fl_proc = 1'b0; fl_addr = 1'b0;
   endtask

   // one command cycle, controls removed again at the following falling edge
   task automatic apply(logic [2:0] op, logic [VW-1:0] vpn, logic [AW-1:0] asn,
                        logic glb, logic [PW-1:0] ppn, logic [3:0] rd, logic [3:0] wr,
                        logic trd, logic twr);
      @(negedge clk);
      ins_vpn = vpn; ins_asn = asn; ins_glb = glb; ins_ppn = ppn;
      ins_rd_ok = rd; ins_wr_ok = wr; ins_trap_rd = trd; ins_trap_wr = twr;
      fl_vpn = vpn; fl_asn = asn;
      ins_en  = (op == OP_INS);
      fl_all  = (op == OP_ALL);
      fl_proc = (op == OP_PROC);
      fl_addr = (op == OP_ADDR);
      @(posedge clk);
      @(negedge clk);
      idle_ctrl();
   endtask

   task automatic probe(string tag, logic [VW-1:0] vpn, logic [AW-1:0] asn,
                        logic ehit, logic [3:0] eidx, logic [PW-1:0] eppn);
      lk_vpn = vpn; lk_asn = asn;
      #1;
      check_val({tag, " hit"}, 32'(lk_hit), 32'(ehit));
      check_val({tag, " idx"}, 32'(lk_idx), ehit ? 32'(eidx) : 32'd0);
      check_val({tag, " ppn"}, 32'(lk_ppn), ehit ? 32'(eppn) : 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog R1..: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state: nothing hits, outputs at zero (R3)
      probe("R1 reset empty", 20'h0, 8'h0, 1'b0, 4'd0, 20'h0);
      check_val("R3 miss masks", 32'({lk_rd_ok, lk_wr_ok, lk_trap_rd, lk_trap_wr}), 32'd0);
      rst_n = 1'b1;

      // vector table: R2 R4 R5 R7 R8 R9
      for (int v = 0; v < NVEC; v++) begin
         if (VECS[v].op != OP_LOOK)
            apply(VECS[v].op, VECS[v].vpn, VECS[v].asn, VECS[v].glb, VECS[v].ppn,
                  4'hF, 4'h3, 1'b0, 1'b0);
         probe($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].cvpn, VECS[v].casn,
               VECS[v].ehit, VECS[v].eidx, VECS[v].eppn);
      end

      // R3 stored fields returned on a hit (pointer now at slot 1)
      apply(OP_INS, 20'hABC, 8'd4, 1'b0, 20'h12345, 4'b1010, 4'b0110, 1'b1, 1'b0);
      probe("R3 fields", 20'hABC, 8'd4, 1'b1, 4'd1, 20'h12345);
      check_val("R3 rd mask", 32'(lk_rd_ok), 32'b1010);
      check_val("R3 wr mask", 32'(lk_wr_ok), 32'b0110);
      check_val("R3 trap flags", 32'({lk_trap_rd, lk_trap_wr}), 32'b10);

      // R11 insert not visible before the edge, visible after it (slot 2)
      @(negedge clk);
      ins_vpn = 20'h777; ins_asn = 8'd3; ins_glb = 1'b0; ins_ppn = 20'h7;
      ins_en = 1'b1;
      probe("R11 before edge", 20'h777, 8'd3, 1'b0, 4'd0, 20'h0);
      @(posedge clk);
      #1;
      check_val("R11 after edge hit", 32'(lk_hit), 32'd1);
      check_val("R11 after edge idx", 32'(lk_idx), 32'd2);
      @(negedge clk);
      idle_ctrl();

      // R6 fill every slot from 0, then one more lands in slot 0
      apply(OP_ALL, 20'h0, 8'd0, 1'b0, 20'h0, 4'h0, 4'h0, 1'b0, 1'b0);
      for (int k = 0; k < DEPTH; k++)
         apply(OP_INS, VW'(32'h1000 + k), 8'd1, 1'b0, PW'(32'h500 + k), 4'hF, 4'hF, 1'b0, 1'b0);
      probe("R5 last slot", 20'h100F, 8'd1, 1'b1, 4'd15, 20'h50F);
      apply(OP_INS, 20'h2000, 8'd1, 1'b0, 20'h900, 4'hF, 4'hF, 1'b0, 1'b0);
      probe("R6 wrap new", 20'h2000, 8'd1, 1'b1, 4'd0, 20'h900);
      probe("R5 overwritten", 20'h1000, 8'd1, 1'b0, 4'd0, 20'h0);

      // R10 insert with a simultaneous flush is dropped, pointer stays at 1
      @(negedge clk);
      ins_vpn = 20'h3000; ins_asn = 8'd1; ins_glb = 1'b0; ins_ppn = 20'h333;
      ins_en = 1'b1; fl_addr = 1'b1; fl_vpn = 20'h9999; fl_asn = 8'd0;
      @(posedge clk);
      @(negedge clk);
      idle_ctrl();
      probe("R10 dropped insert", 20'h3000, 8'd1, 1'b0, 4'd0, 20'h0);
      probe("R10 slot1 intact", 20'h1001, 8'd1, 1'b1, 4'd1, 20'h501);
      apply(OP_INS, 20'h3001, 8'd1, 1'b0, 20'h334, 4'hF, 4'hF, 1'b0, 1'b0);
      probe("R10 pointer held", 20'h3001, 8'd1, 1'b1, 4'd1, 20'h334);

      // R2 all 8 bits of the address-space number compared (slot 2)
      apply(OP_INS, 20'h5000, 8'hFF, 1'b0, 20'h55, 4'hF, 4'hF, 1'b0, 1'b0);
      probe("R2 asn top bit differs", 20'h5000, 8'h7F, 1'b0, 4'd0, 20'h0);
      probe("R2 asn exact", 20'h5000, 8'hFF, 1'b1, 4'd2, 20'h55);

      // R1 reset mid-run clears slots and the pointer
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      probe("R1 reset clears", 20'h5000, 8'hFF, 1'b0, 4'd0, 20'h0);
      apply(OP_INS, 20'h6000, 8'd2, 1'b0, 20'h66, 4'hF, 4'hF, 1'b0, 1'b0);
      probe("R1 pointer at 0", 20'h6000, 8'd2, 1'b1, 4'd0, 20'h66);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule